// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a CPU core and turns interrupt requests into an exception entry. Requests come from three kinds of source: one non-maskable line, a set of external pin lines and a set of on-chip peripheral lines. Each maskable line carries a 4-bit priority level. The block picks one winner and checks it against the CPU's current 4-bit interrupt mask. It waits until the CPU reports that its current sequence is finished, and then runs the entry: two stack pushes, a vector read and the first handler fetch.

The judgement takes longer for pin sources than for the non-maskable and peripheral sources. For the faster sources, the clock phase at which the request arrives decides whether an idle cycle comes first. The entry runs over a simple request/ready bus. Every access may stretch by any number of wait states, and the block adds a fixed five cycles of its own overhead. With single-cycle memory, no extra CPU wait and the favourable phase, a peripheral request reaches its first fetch in 10 cycles and a pin request in 12.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset the block is idle: `bus_req`, `mask_load`, `sp_load` and every acknowledge output are 0.
- R2: Among pending requests whose level is above `sr_mask_in`, the highest level wins. The non-maskable line counts as level 16. On equal levels the non-maskable line wins first, then pin lines in ascending number, then peripheral lines in ascending index.
- R3: A maskable request whose level is equal to or below `sr_mask_in` is never accepted: no acknowledge and no bus access.
- R4: For non-maskable and peripheral winners, judgement takes 2 cycles. It is preceded by 0 idle cycles when `phase_hi` is 1 in the request's first cycle and by 1 idle cycle otherwise.
- R5: For pin winners, judgement takes 1 idle cycle plus 3 judgement cycles.
- R6: After judgement, each cycle in which `seq_done` is 0 delays entry by one cycle.
- R7: If `sr_mask_in` rises to or above the winner's level before entry begins, the request is dropped, even when `seq_done` is 1 in that same cycle. The non-maskable line is never dropped.
- R8: The entry accesses are, in order: a write of `sr_in` to `sp_in`-4; a write of `pc_in` to `sp_in`-8; a read at `vbr` + 4×vector number, where the vector number is 11 for the non-maskable line, 64+n for pin n and 72+n for peripheral n; and a fetch (`bus_fetch`=1) at the address returned by that read.
- R9: From the start of entry to the first fetch cycle takes 5 cycles plus the cycles of the three accesses. An access with w wait states lasts w+1 cycles, so the request-to-fetch total is idle + judgement + CPU wait + 5 + m1 + m2 + m3.
- R10: In the first entry cycle the block pulses exactly one acknowledge bit, that of the winner. In the same cycle it pulses `mask_load`, with `mask_new` equal to the winner's level (15 for the non-maskable line).
- R11: Each access, including the fetch, holds its request and address until `bus_rdy` is 1. After the fetch completes, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | NI | Pin requests |
| irq_lvl | input | 4*NI | Pin levels, 4 bits per pin |
| per_req | input | NP | Peripheral requests |
| per_lvl | input | 4*NP | Peripheral levels, 4 bits per line |
| phase_hi | input | 1 | Clock phase; 1 skips the idle cycle for fast sources |
| sr_mask_in | input | 4 | Current CPU interrupt mask |
| seq_done | input | 1 | CPU current sequence complete |
| sr_in | input | W | Status register value to save |
| pc_in | input | W | Program counter to save |
| sp_in | input | W | Stack pointer before entry |
| vbr | input | W | Vector table base |
| nmi_ack | output | 1 | Non-maskable acknowledge pulse |
| irq_ack | output | NI | Pin acknowledge pulses |
| per_ack | output | NP | Peripheral acknowledge pulses |
| mask_load | output | 1 | Load `mask_new` into the CPU mask |
| mask_new | output | 4 | New mask value |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | W | Stack pointer after both pushes |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Write access |
| bus_fetch | output | 1 | Access is the first handler fetch |
| bus_addr | output | W | Access address |
| bus_wdata | output | W | Write data |
| bus_rdata | input | W | Read data |
| bus_rdy | input | 1 | Access completes this cycle |

## Verification
The end of the CPU's current sequence and a rise of the interrupt mask can land in the same cycle: the last judgement cycle or a CPU-wait cycle. The bench provokes this by raising `sr_mask_in` to 15 and `seq_done` together, at the exact cycle it computes from the source type and phase. For a maskable winner it expects no acknowledge and no bus access. For the non-maskable line it expects a normal entry with the usual latency. Ties between equal levels across source kinds are judged by which acknowledge bit pulses.

// File: rtl/intr_entry_seq.sv
module intr_entry_seq #(
  parameter int NI = 4,
  parameter int NP = 4,
  parameter int W = 32,
  parameter int NMI_VEC = 11,
  parameter int IRQ_VEC0 = 64,
  parameter int PER_VEC0 = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_req,
  input  logic [NI-1:0] irq_req,
  input  logic [4*NI-1:0] irq_lvl,
  input  logic [NP-1:0] per_req,
  input  logic [4*NP-1:0] per_lvl,
  input  logic          phase_hi,
  input  logic [3:0]    sr_mask_in,
  input  logic          seq_done,
  input  logic [W-1:0]  sr_in,
  input  logic [W-1:0]  pc_in,
  input  logic [W-1:0]  sp_in,
  input  logic [W-1:0]  vbr,
  output logic          nmi_ack,
  output logic [NI-1:0] irq_ack,
  output logic [NP-1:0] per_ack,
  output logic          mask_load,
  output logic [3:0]    mask_new,
  output logic          sp_load,
  output logic [W-1:0]  sp_out,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_fetch,
  output logic [W-1:0]  bus_addr,
  output logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  bus_rdata,
  input  logic          bus_rdy
);
  localparam int NS = 1 + NI + NP;
  localparam int SW = $clog2(NS);

  typedef enum logic [3:0] {
    S_IDLE, S_JUDGE, S_WAITX, S_ACC, S_SRSET, S_SRWR, S_PCSET,
    S_PCWR, S_VSET, S_VRD, S_LOAD, S_FETCH
  } st_t;

  st_t st;
  logic [1:0]    cnt;
  logic [SW-1:0] win_i;
  logic [4:0]    win_l;
  logic [W-1:0]  sr_q, pc_q, sp_q, vaddr, handler;

  logic [NS-1:0]   req_v;
  logic [NS*5-1:0] lvl_v;
  logic            found;
  logic [SW-1:0]   best_i;
  logic [4:0]      best_l;

  assign req_v = {per_req, irq_req, nmi_req};

  always_comb begin
    lvl_v[4:0] = 5'd16;
    for (int i = 0; i < NI; i++) lvl_v[5*(1+i) +: 5] = {1'b0, irq_lvl[4*i +: 4]};
    for (int i = 0; i < NP; i++) lvl_v[5*(1+NI+i) +: 5] = {1'b0, per_lvl[4*i +: 4]};
  end

  always_comb begin
    found = 1'b0;
    best_i = '0;
    best_l = '0;
    for (int s = 0; s < NS; s++) begin
      if (req_v[s] && lvl_v[5*s +: 5] > {1'b0, sr_mask_in} &&
          (!found || lvl_v[5*s +: 5] > best_l)) begin
        found = 1'b1;
        best_i = SW'(s);
        best_l = lvl_v[5*s +: 5];
      end
    end
  end

  function automatic logic [W-1:0] vec_of(input logic [SW-1:0] i);
    int n;
    n = int'(i);
    if (n == 0) return W'(NMI_VEC);
    else if (n <= NI) return W'(IRQ_VEC0 + n - 1);
    else return W'(PER_VEC0 + n - 1 - NI);
  endfunction

  wire still_ok = win_l > {1'b0, sr_mask_in};
  wire win_is_irq = (int'(win_i) >= 1) && (int'(win_i) <= NI);
  wire best_is_irq = (int'(best_i) >= 1) && (int'(best_i) <= NI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      win_i <= '0;
      win_l <= '0;
      sr_q <= '0;
      pc_q <= '0;
      sp_q <= '0;
      vaddr <= '0;
      handler <= '0;
    end else begin
      case (st)
        S_IDLE: if (found) begin
          win_i <= best_i;
          win_l <= best_l;
          cnt <= best_is_irq ? 2'd3 : (phase_hi ? 2'd1 : 2'd2);
          st <= S_JUDGE;
        end
        S_JUDGE: begin
          if (cnt != 2'd1) cnt <= cnt - 2'd1;
          else if (!still_ok) st <= S_IDLE;
          else if (seq_done) st <= S_ACC;
          else st <= S_WAITX;
        end
        S_WAITX: begin
          if (!still_ok) st <= S_IDLE;
          else if (seq_done) st <= S_ACC;
        end
        S_ACC: begin
          sr_q <= sr_in;
          pc_q <= pc_in;
          sp_q <= sp_in - W'(4);
          vaddr <= vbr + (vec_of(win_i) << 2);
          st <= S_SRSET;
        end
        S_SRSET: st <= S_SRWR;
        S_SRWR: if (bus_rdy) begin
          sp_q <= sp_q - W'(4);
          st <= S_PCSET;
        end
        S_PCSET: st <= S_PCWR;
        S_PCWR: if (bus_rdy) st <= S_VSET;
        S_VSET: st <= S_VRD;
        S_VRD: if (bus_rdy) begin
          handler <= bus_rdata;
          st <= S_LOAD;
        end
        S_LOAD: st <= S_FETCH;
        S_FETCH: if (bus_rdy) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [NS-1:0] ack_v;
  assign ack_v = (st == S_ACC) ? (NS'(1) << win_i) : '0;
  assign nmi_ack = ack_v[0];
  assign irq_ack = ack_v[NI:1];
  assign per_ack = ack_v[NS-1:NI+1];
  assign mask_load = st == S_ACC;
  assign mask_new = win_l[4] ? 4'hF : win_l[3:0];
  assign sp_load = st == S_LOAD;
  assign sp_out = sp_q;

  assign bus_req = st inside {S_SRWR, S_PCWR, S_VRD, S_FETCH};
  assign bus_we = st inside {S_SRWR, S_PCWR};
  assign bus_fetch = st == S_FETCH;
  assign bus_addr = (st == S_VRD) ? vaddr : (st == S_FETCH) ? handler : sp_q;
  assign bus_wdata = (st == S_PCWR) ? pc_q : sr_q;

  wire unused_ok = win_is_irq;
endmodule

module intr_entry_seq_chk #(
  parameter int NI = 4,
  parameter int NP = 4,
  parameter int W = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_ack,
  input logic [NI-1:0] irq_ack,
  input logic [NP-1:0] per_ack,
  input logic          mask_load,
  input logic [W-1:0]  sp_in,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_fetch,
  input logic [W-1:0]  bus_addr,
  input logic          bus_rdy
);
  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_ack, irq_ack, nmi_ack}));

  // R8
  first_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_load, 2) |-> bus_req && bus_we && bus_addr == $past(sp_in, 2) - W'(4));

  // R11
  hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr));

  // R11
  fetch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_fetch && bus_rdy |=> !bus_req);
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.NI(NI), .NP(NP), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_ack(nmi_ack), .irq_ack(irq_ack),
  .per_ack(per_ack), .mask_load(mask_load), .sp_in(sp_in),
  .bus_req(bus_req), .bus_we(bus_we), .bus_fetch(bus_fetch),
  .bus_addr(bus_addr), .bus_rdy(bus_rdy)
);

// File: tb/intr_entry_seq_tb.sv
module intr_entry_seq_tb;
  localparam int NI = 4, NP = 4, W = 32;
  localparam logic [W-1:0] SP = 32'h2000_0100, PC = 32'h0000_1234;
  localparam logic [W-1:0] SR = 32'h0000_00A1, VB = 32'h0000_0400;

  logic clk = 0, rst_n = 0;
  logic nmi_req = 0, phase_hi = 0, seq_done = 1, bus_rdy = 0;
  logic [NI-1:0] irq_req = '0;
  logic [NP-1:0] per_req = '0;
  logic [4*NI-1:0] irq_lvl = '0;
  logic [4*NP-1:0] per_lvl = '0;
  logic [3:0] sr_mask_in = '0, mask_new;
  logic [W-1:0] sr_in = SR, pc_in = PC, sp_in = SP, vbr = VB, bus_rdata = '0;
  logic nmi_ack, mask_load, sp_load, bus_req, bus_we, bus_fetch;
  logic [NI-1:0] irq_ack;
  logic [NP-1:0] per_ack;
  logic [W-1:0] sp_out, bus_addr, bus_wdata;

  intr_entry_seq #(.NI(NI), .NP(NP), .W(W)) u_dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // kind: 0 non-maskable, 1 pin, 2 peripheral, 3 none accepted
  task automatic run(input logic n, input logic [NI-1:0] ir, input logic [NP-1:0] pr,
                     input logic [3:0] mk, input logic ph, input int w1, input int w2,
                     input int w3, input int x, input int fw, input int ek, input int ei,
                     input logic [3:0] emask, input bit raise);
    int wt[4], idle, judge, jl, wc, tx, lat, fc, nack, ev;
    logic [W-1:0] a[4], d[4], hnd;
    logic we[4];
    logic [NI+NP:0] apat, eapat;
    wt = '{w1, w2, w3, fw};
    idle = (ek == 1) ? 1 : (ph ? 0 : 1);
    judge = (ek == 1) ? 3 : 2;
    jl = idle + judge - 1;
    ev = (ek == 0) ? 11 : (ek == 1) ? 64 + ei : 72 + ei;
    hnd = 32'h0001_0000 + W'(ev * 16);
    eapat = (ek == 0) ? 1 : (ek == 1) ? (NI+NP+1)'(2 << ei) : (NI+NP+1)'(1 << (1 + NI + ei));
    wc = 0; tx = 0; lat = -1; fc = 0; nack = 0; apat = '0;
    for (int i = 0; i < 4; i++) begin a[i] = '0; d[i] = '0; we[i] = 0; end
    @(negedge clk);
    sr_mask_in = mk; phase_hi = ph; nmi_req = n; irq_req = ir; per_req = pr;
    seq_done = (jl + x == 0);
    for (int k = 1; k < 45; k++) begin
      @(negedge clk);
      seq_done = (k >= jl + x);
      if (raise && k == jl + x) sr_mask_in = 4'hF;
      if (|{per_ack, irq_ack, nmi_ack}) begin
        nack++; apat = {per_ack, irq_ack, nmi_ack};
        chk(mask_load && mask_new == emask, "R10 mask_new", mask_new, emask);
        nmi_req = 0; irq_req = '0; per_req = '0;
      end
      if (bus_req && tx < 4) begin
        if (bus_fetch) fc++;
        if (wc == 0) begin
          a[tx] = bus_addr; d[tx] = bus_wdata; we[tx] = bus_we;
          if (bus_fetch && lat < 0) lat = k;
        end
        if (wc == wt[tx]) begin
          bus_rdy = 1;
          bus_rdata = (tx == 2) ? hnd : 32'hDEAD_BEEF;
          wc = 0; tx++;
        end else begin
          bus_rdy = 0; wc++;
        end
      end else bus_rdy = 0;
    end
    if (ek == 3) begin
      chk(nack == 0, "R3 R7 no acknowledge", nack, 0);
      chk(tx == 0, "R3 R7 no bus access", tx, 0);
    end else begin
      chk(nack == 1 && apat == eapat, "R2 R10 winner ack", apat, eapat);
      chk(lat == idle + judge + x + 5 + w1 + w2 + w3 + 3, "R4 R5 R6 R9 latency", lat,
          idle + judge + x + 5 + w1 + w2 + w3 + 3);
      chk(we[0] && a[0] == SP - 4 && d[0] == SR, "R8 SR push", a[0], SP - 4);
      chk(we[1] && a[1] == SP - 8 && d[1] == PC, "R8 PC push", a[1], SP - 8);
      chk(!we[2] && a[2] == VB + W'(ev * 4), "R8 vector read", a[2], VB + W'(ev * 4));
      chk(a[3] == hnd, "R8 fetch address", a[3], hnd);
      chk(fc == fw + 1 && !bus_req, "R11 fetch held until ready", fc, fw + 1);
    end
    nmi_req = 0; irq_req = '0; per_req = '0; sr_mask_in = 0; seq_done = 1; bus_rdy = 0;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] kind; logic [1:0] idx; logic [3:0] lvl; logic [3:0] mask;
    logic ph; logic [1:0] w1; logic [1:0] w2; logic [1:0] w3; logic [1:0] x;
  } row_t;

  localparam row_t TBL [6] = '{
    '{2'd2, 2'd0, 4'd5,  4'd0,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0},
    '{2'd1, 2'd0, 4'd5,  4'd0,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0},
    '{2'd2, 2'd2, 4'd9,  4'd3,  1'b0, 2'd1, 2'd2, 2'd0, 2'd0},
    '{2'd1, 2'd3, 4'd15, 4'd14, 1'b1, 2'd0, 2'd0, 2'd3, 2'd2},
    '{2'd0, 2'd0, 4'd0,  4'd15, 1'b1, 2'd2, 2'd1, 2'd1, 2'd1},
    '{2'd2, 2'd1, 4'd7,  4'd6,  1'b1, 2'd3, 2'd3, 2'd3, 2'd3}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!bus_req && !mask_load && !sp_load && !nmi_ack && irq_ack == 0 && per_ack == 0,
        "R1 reset idle", bus_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    foreach (TBL[t]) begin
      logic [NI-1:0] ir;
      logic [NP-1:0] pr;
      ir = '0; pr = '0;
      if (TBL[t].kind == 1) begin ir[TBL[t].idx] = 1; irq_lvl[4*TBL[t].idx +: 4] = TBL[t].lvl; end
      if (TBL[t].kind == 2) begin pr[TBL[t].idx] = 1; per_lvl[4*TBL[t].idx +: 4] = TBL[t].lvl; end
      run(TBL[t].kind == 0, ir, pr, TBL[t].mask, TBL[t].ph, TBL[t].w1, TBL[t].w2,
          TBL[t].w3, TBL[t].x, 0, TBL[t].kind, TBL[t].idx,
          TBL[t].kind == 0 ? 4'hF : TBL[t].lvl, 0);
    end

    // R3 level equal to or below mask
    irq_lvl = {4'd1, 4'd1, 4'd1, 4'd4}; per_lvl = {4'd0, 4'd0, 4'd2, 4'd0};
    run(0, 4'b0001, 4'b0010, 4'd4, 1, 0, 0, 0, 0, 0, 3, 0, 0, 0);
    // R2 equal levels: pin 1 beats pin 2 and peripheral 0
    irq_lvl = {4'd0, 4'd8, 4'd8, 4'd0}; per_lvl = {4'd0, 4'd0, 4'd0, 4'd8};
    run(0, 4'b0110, 4'b0001, 4'd0, 1, 0, 0, 0, 0, 0, 1, 1, 4'd8, 0);
    // R2 higher level peripheral beats lower pin
    irq_lvl = {4'd0, 4'd0, 4'd0, 4'd9}; per_lvl = {4'd10, 4'd0, 4'd0, 4'd0};
    run(0, 4'b0001, 4'b1000, 4'd0, 0, 0, 0, 0, 0, 0, 2, 3, 4'd10, 0);
    // R2 non-maskable beats level 15 pin
    irq_lvl = {4'd0, 4'd0, 4'd0, 4'd15};
    run(1, 4'b0001, 4'b0000, 4'd0, 1, 0, 0, 0, 0, 0, 0, 0, 4'hF, 0);
    // R7 mask rises with seq_done in the same cycle (during CPU wait)
    irq_lvl = {4'd0, 4'd0, 4'd0, 4'd6};
    run(0, 4'b0001, 4'b0000, 4'd2, 0, 0, 0, 0, 1, 0, 3, 0, 0, 1);
    // R7 same at the last judgement cycle
    per_lvl = {4'd0, 4'd0, 4'd0, 4'd6};
    run(0, 4'b0000, 4'b0001, 4'd2, 1, 0, 0, 0, 0, 0, 3, 0, 0, 1);
    // R7 non-maskable is not dropped
    run(1, 4'b0000, 4'b0000, 4'd2, 1, 0, 0, 0, 1, 0, 0, 0, 4'hF, 1);
    // R11 fetch with wait states
    per_lvl = {4'd0, 4'd0, 4'd3, 4'd0};
    run(0, 4'b0000, 4'b0010, 4'd0, 1, 0, 0, 0, 0, 2, 2, 1, 4'd3, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule